// File: doc/BRIEF.md
# Windowed I/Q Running-Sum Magnitude Detector

This block takes signed in-phase and quadrature cycle sums, one pair per modulation cycle, each marked by a single-clock valid strobe. It keeps a moving sum over the 64 most recent entries of each component. Each component has its own circular store. On every accepted pair, the store drops the entry it overwrites from its running sum and adds the new one. Each update therefore costs the same fixed amount of work, however long the block has been running.

One clock after each accepted pair, the block presents a magnitude estimate with an output strobe. The estimate is the absolute value of the in-phase running sum plus the absolute value of the quadrature running sum, so no square root is needed. After reset both stores are empty. Under a steady input the estimate rises over the first 64 cycles and then stays flat. A downstream stage thresholds or scales this value. The block does neither.

Top module: `iq_window_magnitude`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `out_valid` is 0 and `out_mag` is 0. Reset empties both stores, both running sums and the shared slot pointer.
- R2: `out_valid` is 1 on exactly the clock after each clock on which `in_valid` is 1, and 0 otherwise. Back-to-back strobes give back-to-back output strobes.
- R3: With each output strobe, `out_mag` equals |SI| + |SQ|. SI is the sum of the most recent up-to-64 accepted `in_i` values and SQ is the sum of the matching `in_q` values. Slots not yet written count as 0.
- R4: The window is exactly 64 entries. A value accepted N updates ago still counts for N < 64. On the 64th later update it is replaced and leaves the sum, as the slot pointer wraps from 63 to 0.
- R5: After reset, a constant pair (a, b) presented repeatedly gives k·(|a|+|b|) on update k for k ≤ 64. The output is then flat at 64·(|a|+|b|).
- R6: On clocks where `in_valid` is 0, `in_i` and `in_q` are ignored. `out_mag` holds its value and neither the running sums nor the stores change.
- R7: Full-scale inputs do not overflow. Sixty-four pairs of (-131072, -131072) give 16777216, and sixty-four pairs of (131071, 131071) give 16777088.
- R8: The absolute value is taken for each component separately. (500, -500) accepted three times gives 3000, and the sign of each component never cancels the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: accept one I/Q cycle-sum pair this clock |
| in_i | input | 18 | In-phase cycle sum, two's complement |
| in_q | input | 18 | Quadrature cycle sum, two's complement |
| out_valid | output | 1 | Strobe: new magnitude on `out_mag` |
| out_mag | output | 25 | Unsigned magnitude \|SI\| + \|SQ\| |

## Verification
A stale or corrupt slot in either store stays hidden until the pointer comes back to that slot. The error then appears in `out_mag` exactly 64 updates after the bad write, so the bench checks every output across windows longer than 64 updates. An off-by-one in the pointer wrap shows as an impulse that leaves the sum one update early or late. A running sum that drifts or absorbs an unstrobed input shows on the next output strobe, because the expected magnitude is compared on every update. A wrong abs or sign extension shows at once with negative or full-scale inputs.

// File: rtl/iqwin_pkg.sv
package iqwin_pkg;

    // Default widths of the detector datapath
    localparam int DEF_SAMPLE_W = 18;
    localparam int DEF_ACC_W    = 24;
    localparam int DEF_DEPTH    = 64;

    // Component selector used to index the per-component datapath copies
    typedef enum logic {
        COMP_INPHASE = 1'b0,
        COMP_QUAD    = 1'b1
    } comp_e;

    localparam int NUM_COMP = 2;

    // Width needed to hold |a| + |b| for two ACC_W-bit signed values
    function automatic int mag_width(input int acc_w);
        return acc_w + 1;
    endfunction

endpackage

// File: rtl/iqwin_ptr.sv
module iqwin_ptr #(
    parameter int DEPTH = 64,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [PTR_W-1:0] slot
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0] slot_r;

    always_ff @(posedge clk) begin
        if (rst)
            slot_r <= '0;
        else if (adv)
            slot_r <= (slot_r == LAST) ? '0 : slot_r + 1'b1;
    end

    assign slot = slot_r;

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && slot_r == LAST) |=> (slot_r == '0));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(slot_r));

endmodule

// File: rtl/iqwin_window.sv
module iqwin_window #(
    parameter int SAMPLE_W = 18,
    parameter int ACC_W    = 24,
    parameter int DEPTH    = 64,
    localparam int PTR_W   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [PTR_W-1:0]           slot,
    input  logic signed [SAMPLE_W-1:0] din,
    output logic signed [ACC_W-1:0]    sum_cur,
    output logic signed [ACC_W-1:0]    sum_nxt
);
    logic signed [SAMPLE_W-1:0] ring [DEPTH];
    logic signed [ACC_W-1:0]    acc_r;
    logic signed [ACC_W-1:0]    leaving_ext;
    logic signed [ACC_W-1:0]    arriving_ext;

    // Sign-extend the retiring and incoming entries to the accumulator width
    assign leaving_ext  = ACC_W'(ring[slot]);
    assign arriving_ext = ACC_W'(din);

    always_comb begin
        if (wr_en)
            sum_nxt = acc_r - leaving_ext + arriving_ext;
        else
            sum_nxt = acc_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++)
                ring[k] <= '0;
            acc_r <= '0;
        end else if (wr_en) begin
            ring[slot] <= din;
            acc_r      <= sum_nxt;
        end
    end

    assign sum_cur = acc_r;

    // R6
    sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(acc_r));

    // R1
    sum_reset_chk: assert property (@(posedge clk)
        rst |=> (acc_r == '0));

endmodule

// File: rtl/iqwin_mag.sv
module iqwin_mag #(
    parameter int ACC_W = 24,
    localparam int MAG_W = ACC_W + 1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd,
    input  logic signed [ACC_W-1:0] si_nxt,
    input  logic signed [ACC_W-1:0] sq_nxt,
    input  logic signed [ACC_W-1:0] si_cur,
    input  logic signed [ACC_W-1:0] sq_cur,
    output logic                    vld,
    output logic [MAG_W-1:0]        mag
);
    function automatic logic [ACC_W-1:0] absval(input logic signed [ACC_W-1:0] x);
        return x[ACC_W-1] ? ACC_W'(-x) : ACC_W'(x);
    endfunction

    logic [MAG_W-1:0] mag_nxt;
    logic [MAG_W-1:0] mag_r;
    logic             vld_r;

    assign mag_nxt = MAG_W'(absval(si_nxt)) + MAG_W'(absval(sq_nxt));

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_r <= '0;
            vld_r <= 1'b0;
        end else begin
            vld_r <= upd;
            if (upd)
                mag_r <= mag_nxt;
        end
    end

    assign vld = vld_r;
    assign mag = mag_r;

    // R2
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> vld_r);

    // R2
    vld_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> !vld_r);

    // R6
    mag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(mag_r));

    // R3
    mag_value_chk: assert property (@(posedge clk) disable iff (rst)
        vld_r |-> (mag_r == MAG_W'(absval(si_cur)) + MAG_W'(absval(sq_cur))));

    // R1
    mag_reset_chk: assert property (@(posedge clk)
        rst |=> (mag_r == '0 && !vld_r));

endmodule

// File: rtl/iq_window_magnitude.sv
module iq_window_magnitude
    import iqwin_pkg::*;
#(
    parameter int SAMPLE_W = DEF_SAMPLE_W,
    parameter int ACC_W    = DEF_ACC_W,
    parameter int DEPTH    = DEF_DEPTH,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int MAG_W   = mag_width(ACC_W)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] in_i,
    input  logic signed [SAMPLE_W-1:0] in_q,
    output logic                       out_valid,
    output logic [MAG_W-1:0]           out_mag
);
    logic [PTR_W-1:0]           slot;
    logic signed [SAMPLE_W-1:0] comp_in  [NUM_COMP];
    logic signed [ACC_W-1:0]    comp_cur [NUM_COMP];
    logic signed [ACC_W-1:0]    comp_nxt [NUM_COMP];

    assign comp_in[COMP_INPHASE] = in_i;
    assign comp_in[COMP_QUAD]    = in_q;

    iqwin_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .adv  (in_valid),
        .slot (slot)
    );

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
        iqwin_window #(
            .SAMPLE_W (SAMPLE_W),
            .ACC_W    (ACC_W),
            .DEPTH    (DEPTH)
        ) u_win (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (in_valid),
            .slot    (slot),
            .din     (comp_in[c]),
            .sum_cur (comp_cur[c]),
            .sum_nxt (comp_nxt[c])
        );
    end

    iqwin_mag #(.ACC_W(ACC_W)) u_mag (
        .clk    (clk),
        .rst    (rst),
        .upd    (in_valid),
        .si_nxt (comp_nxt[COMP_INPHASE]),
        .sq_nxt (comp_nxt[COMP_QUAD]),
        .si_cur (comp_cur[COMP_INPHASE]),
        .sq_cur (comp_cur[COMP_QUAD]),
        .vld    (out_valid),
        .mag    (out_mag)
    );

endmodule

// File: tb/iq_window_magnitude_test.sv
`timescale 1ns/1ps
module iq_window_magnitude_test;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [17:0] in_i = '0;
    logic signed [17:0] in_q = '0;
    logic               out_valid;
    logic [24:0]        out_mag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Independent reference of the 64-deep windows
    int mi [64];
    int mq [64];
    int mptr = 0;
    longint msi = 0;
    longint msq = 0;

    always #2.5 clk = ~clk;

    iq_window_magnitude uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_mag(out_mag)
    );

    localparam int VEC_N = 8;
    localparam int TAB_I [VEC_N] = '{100, 131071, -5, 0, -1736, 19484, -20418, -20475};
    localparam int TAB_Q [VEC_N] = '{-200, -131072, 7, 0, -246, 19484, 20418, -20475};
    localparam longint TAB_E [VEC_N] = '{300, 262443, 262431, 262431, 260941, 260941, 220105, 220105};

    function automatic longint labs(input longint x);
        return (x < 0) ? -x : x;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 64; k++) begin
            mi[k] = 0;
            mq[k] = 0;
        end
        mptr = 0;
        msi = 0;
        msq = 0;
    endtask

    // Called at a falling edge; returns at the next falling edge with valid low
    task automatic push(input int vi, input int vq, input string req, input bit chk);
        in_valid = 1'b1;
        in_i = 18'(vi);
        in_q = 18'(vq);
        msi = msi - mi[mptr] + vi;
        msq = msq - mq[mptr] + vq;
        mi[mptr] = vi;
        mq[mptr] = vq;
        mptr = (mptr + 1) % 64;
        @(negedge clk);
        in_valid = 1'b0;
        if (chk) begin
            check({req, " strobe"}, longint'(out_valid), 1);
            check(req, longint'(out_mag), labs(msi) + labs(msq));
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 strobe in reset", longint'(out_valid), 0);
        check("R1 mag in reset", longint'(out_mag), 0);
        rst = 1'b0;
        model_clear();
        @(negedge clk);
        check("R1 strobe after reset", longint'(out_valid), 0);
        check("R1 mag after reset", longint'(out_mag), 0);
    endtask

    initial begin
        model_clear();
        @(negedge clk);
        do_reset();

        // R3 / R2: table of vectors, back to back
        for (int v = 0; v < VEC_N; v++) begin
            push(TAB_I[v], TAB_Q[v], "R3 table", 1'b0);
            check("R2 strobe", longint'(out_valid), 1);
            check("R3 table value", longint'(out_mag), TAB_E[v]);
        end

        // R6: inputs wiggle with no strobe
        begin
            longint held;
            held = out_mag;
            for (int k = 0; k < 5; k++) begin
                in_i = 18'(12345 * (k + 1));
                in_q = 18'(-777 * (k + 1));
                @(negedge clk);
                check("R2 no strobe when idle", longint'(out_valid), 0);
                check("R6 mag holds", longint'(out_mag), held);
            end
            push(0, 0, "R6 sums untouched", 1'b0);
            check("R6 sums untouched", longint'(out_mag), 220105);
        end

        // R4: an impulse stays exactly 64 updates
        do_reset();
        push(1000, 0, "R4 impulse", 1'b1);
        for (int k = 1; k < 64; k++) begin
            push(0, 0, "R4 inside window", 1'b0);
            check("R4 inside window", longint'(out_mag), 1000);
        end
        push(0, 0, "R4 dropped", 1'b0);
        check("R4 dropped on 64th later update", longint'(out_mag), 0);

        // R5: ramp then level
        do_reset();
        for (int k = 1; k <= 74; k++) begin
            push(300, -100, "R5", 1'b0);
            check("R5 ramp/level", longint'(out_mag), (k <= 64) ? 400 * k : 25600);
        end

        // R7: full scale
        do_reset();
        for (int k = 0; k < 64; k++) push(-131072, -131072, "R7 neg", 1'b1);
        check("R7 negative full scale", longint'(out_mag), 16777216);
        for (int k = 0; k < 64; k++) push(131071, 131071, "R7 pos", 1'b1);
        check("R7 positive full scale", longint'(out_mag), 16777088);

        // R8: per-component absolute value
        do_reset();
        for (int k = 0; k < 3; k++) push(500, -500, "R8", 1'b1);
        check("R8 opposite signs", longint'(out_mag), 3000);
        push(-1500, 1500, "R8 to zero", 1'b1);
        check("R8 both to zero", longint'(out_mag), 0);

        // R1: reset in the middle of a run
        push(7000, -3000, "R1 before reset", 1'b1);
        do_reset();
        push(1, 1, "R1 fresh start", 1'b1);
        check("R1 fresh start", longint'(out_mag), 2);

        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule